// File: doc/BRIEF.md
# Synchronous Dual-Port Word Memory

This block is a word-organised static memory with two fully independent ports. Each port has its own clock, address, write data, read/write select, a pair of chip enables, two byte-lane controls and an output enable. Either port can read or write any word at any time, including the word the other port is using in the same cycle. A word is split into a lower lane and an upper lane, and writes and read data are handled lane by lane.

Each port has a static mode pin. In flow-through mode, read data comes out of the register loaded at the clock edge that samples the address. In pipelined mode, it passes through a second register and appears one edge later. Output enable drives a data-valid flag instead of a tri-state pad. Depth and word width are parameters. Addresses come from a separate counter block.

When both ports hit the same word on a shared clock edge, writes resolve per lane in favour of port A. A read that meets a write from the other port returns the word as it stood before that edge.

Top module: `dpram_top`

## Requirements
- R1: A word written through either port can be read back through either port. Every address in the range 0 to 2**ADDR_W-1 is reachable from both ports.
- R2: When `x_pipe` is 0, a read sampled at clock edge k drives `x_rvalid` high and the word on `x_rdata` after edge k.
- R3: When `x_pipe` is 1, a read sampled at edge k drives `x_rvalid` high and the word on `x_rdata` after edge k+1. The result of edge k stays hidden until then.
- R4: A port is selected only when `x_ce0_n` is 0 and `x_ce1` is 1. A deselected port writes nothing, and the read it samples gives `x_rvalid` 0 and `x_rdata` 0.
- R5: The lower lane is bits [LO_W-1:0], where LO_W = DATA_W/2. The upper lane is the remaining bits. A write updates the lower lane only when `x_lb_n` is 0 and the upper lane only when `x_ub_n` is 0.
- R6: On a read, a lane whose control (`x_lb_n` or `x_ub_n`) was 1 at the sampling edge is returned as zeros.
- R7: While `x_oe_n` is 1, `x_rvalid` is 0 and `x_rdata` is 0, in the same cycle. When `x_oe_n` returns to 0, the held result reappears.
- R8: When both ports write the same address on the same edge, each lane that port A writes takes port A's data. A lane written only by port B takes port B's data.
- R9: A read on one port at the same edge and address as a write on the other port returns the data from before that edge.
- R10: A cycle with `x_rw_n` = 0 (write) gives `x_rvalid` 0 for that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| b_clk | input | 1 | Port B clock |
| rst_n | input | 1 | Active-low asynchronous reset of the output registers |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rw_n | input | 1 | Port A: 1 read, 0 write |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_ub_n | input | 1 | Port A upper-lane control, active low |
| a_lb_n | input | 1 | Port A lower-lane control, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_pipe | input | 1 | Port A mode: 0 flow-through, 1 pipelined |
| a_rdata | output | DATA_W | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rw_n | input | 1 | Port B: 1 read, 0 write |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_ub_n | input | 1 | Port B upper-lane control, active low |
| b_lb_n | input | 1 | Port B lower-lane control, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_pipe | input | 1 | Port B mode: 0 flow-through, 1 pipelined |
| b_rdata | output | DATA_W | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The bench builds the block with DATA_W = 18 and ADDR_W = 6. The 18-bit word gives the odd 9-bit lanes, and the 64-word array is small enough to fill completely and read back from both ports. Both port clocks come from one source, so same-edge collisions are well defined. The random phase keeps addresses within eight words, which makes write-write and read-write collisions frequent. Mode, output-enable and chip-enable changes are mixed in while results are still in flight.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  // Width of the lower byte lane for a given word width.
  function automatic int lo_width(input int word_w);
    return word_w / 2;
  endfunction
endpackage

// File: rtl/dpram_bank.sv
// Single-writer storage bank with two combinational read taps.
module dpram_bank #(
  parameter int W    = 18,
  parameter int LO_W = 9,
  parameter int AW   = 10
) (
  input  logic          clk,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1
);
  localparam int DEPTH = 2 ** AW;

  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we_lo) mem[waddr][LO_W-1:0] <= wdata[LO_W-1:0];
    if (we_hi) mem[waddr][W-1:LO_W] <= wdata[W-1:LO_W];
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/dpram_port.sv
// Per-port control: select decode, lane write enables, output stages.
module dpram_port #(
  parameter int W    = 18,
  parameter int LO_W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce0_n,
  input  logic         ce1,
  input  logic         rw_n,
  input  logic         ub_n,
  input  logic         lb_n,
  input  logic         oe_n,
  input  logic         pipe_i,
  input  logic [W-1:0] word_i,
  output logic         we_lo_o,
  output logic         we_hi_o,
  output logic [W-1:0] rdata_o,
  output logic         rvalid_o
);
  logic         sel, rd_req;
  logic [W-1:0] lane_mask;
  logic         s1_v, s2_v;
  logic [W-1:0] s1_d, s2_d;
  logic         pick_v;
  logic [W-1:0] pick_d;

  assign sel     = !ce0_n && ce1;
  assign rd_req  = sel && rw_n;
  assign we_lo_o = sel && !rw_n && !lb_n;
  assign we_hi_o = sel && !rw_n && !ub_n;

  assign lane_mask = {{(W-LO_W){!ub_n && rd_req}}, {LO_W{!lb_n && rd_req}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_d <= '0;
      s2_v <= 1'b0;
      s2_d <= '0;
    end else begin
      s1_v <= rd_req;
      s1_d <= word_i & lane_mask;
      s2_v <= s1_v;
      s2_d <= s1_d;
    end
  end

  assign pick_v   = pipe_i ? s2_v : s1_v;
  assign pick_d   = pipe_i ? s2_d : s1_d;
  assign rvalid_o = pick_v && !oe_n;
  assign rdata_o  = oe_n ? '0 : pick_d;

  a_r2_read_captured: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> s1_v);
  a_r3_pipe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> s2_v);
  a_r4_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo_o || we_hi_o) |-> (!ce0_n && ce1 && !rw_n));
  a_r7_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rvalid_o && rdata_o == '0));
  a_r10_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |=> !s1_v);
endmodule

// File: rtl/dpram_top.sv
// Two-port memory: one data bank and one lane-owner bank per port.
module dpram_top #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              a_clk,
  input  logic              b_clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_rw_n,
  input  logic              a_ce0_n,
  input  logic              a_ce1,
  input  logic              a_ub_n,
  input  logic              a_lb_n,
  input  logic              a_oe_n,
  input  logic              a_pipe,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_rw_n,
  input  logic              b_ce0_n,
  input  logic              b_ce1,
  input  logic              b_ub_n,
  input  logic              b_lb_n,
  input  logic              b_oe_n,
  input  logic              b_pipe,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);
  localparam int LO_W = dpram_pkg::lo_width(DATA_W);
  localparam int NP   = 2;

  logic              clk_v   [NP];
  logic [ADDR_W-1:0] addr_v  [NP];
  logic [DATA_W-1:0] wdata_v [NP];
  logic              rw_v    [NP];
  logic              ce0_v   [NP];
  logic              ce1_v   [NP];
  logic              ub_v    [NP];
  logic              lb_v    [NP];
  logic              oe_v    [NP];
  logic              pipe_v  [NP];
  logic [DATA_W-1:0] rdata_v [NP];
  logic              rvld_v  [NP];

  logic [DATA_W-1:0] dat_rd [NP][NP];  // [bank][reading port]
  logic [1:0]        own_rd [NP][NP];
  logic              we_lo_v [NP];
  logic              we_hi_v [NP];
  logic [DATA_W-1:0] word_v  [NP];
  logic [1:0]        own_wd  [NP];
  logic [1:0]        own_we  [NP];
  logic              same_addr;

  assign clk_v[0] = a_clk;    assign clk_v[1] = b_clk;
  assign addr_v[0] = a_addr;  assign addr_v[1] = b_addr;
  assign wdata_v[0] = a_wdata; assign wdata_v[1] = b_wdata;
  assign rw_v[0] = a_rw_n;    assign rw_v[1] = b_rw_n;
  assign ce0_v[0] = a_ce0_n;  assign ce0_v[1] = b_ce0_n;
  assign ce1_v[0] = a_ce1;    assign ce1_v[1] = b_ce1;
  assign ub_v[0] = a_ub_n;    assign ub_v[1] = b_ub_n;
  assign lb_v[0] = a_lb_n;    assign lb_v[1] = b_lb_n;
  assign oe_v[0] = a_oe_n;    assign oe_v[1] = b_oe_n;
  assign pipe_v[0] = a_pipe;  assign pipe_v[1] = b_pipe;
  assign a_rdata = rdata_v[0]; assign a_rvalid = rvld_v[0];
  assign b_rdata = rdata_v[1]; assign b_rvalid = rvld_v[1];

  assign same_addr = (addr_v[0] == addr_v[1]);

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [1:0] lane_own;  // per lane: 1 means bank 1 holds the newest data
    assign lane_own = own_rd[0][p] ^ own_rd[1][p];
    assign word_v[p] = {
      lane_own[1] ? dat_rd[1][p][DATA_W-1:LO_W] : dat_rd[0][p][DATA_W-1:LO_W],
      lane_own[0] ? dat_rd[1][p][LO_W-1:0]      : dat_rd[0][p][LO_W-1:0]};

    dpram_port #(.W(DATA_W), .LO_W(LO_W)) u_port (
      .clk(clk_v[p]), .rst_n(rst_n), .ce0_n(ce0_v[p]), .ce1(ce1_v[p]),
      .rw_n(rw_v[p]), .ub_n(ub_v[p]), .lb_n(lb_v[p]), .oe_n(oe_v[p]),
      .pipe_i(pipe_v[p]), .word_i(word_v[p]),
      .we_lo_o(we_lo_v[p]), .we_hi_o(we_hi_v[p]),
      .rdata_o(rdata_v[p]), .rvalid_o(rvld_v[p]));

    dpram_bank #(.W(DATA_W), .LO_W(LO_W), .AW(ADDR_W)) u_data (
      .clk(clk_v[p]), .we_lo(we_lo_v[p]), .we_hi(we_hi_v[p]),
      .waddr(addr_v[p]), .wdata(wdata_v[p]),
      .ra0(addr_v[0]), .ra1(addr_v[1]),
      .rd0(dat_rd[p][0]), .rd1(dat_rd[p][1]));

    if (p == 0) begin : g_first
      // Port A claims a lane by copying the other owner bit (xor becomes 0).
      assign own_wd[p] = own_rd[1][0];
      assign own_we[p] = {we_hi_v[0], we_lo_v[0]};
    end else begin : g_second
      // Port B claims by inverting; it yields lanes port A writes on this edge.
      assign own_wd[p] = ~own_rd[0][1];
      assign own_we[p] = {we_hi_v[1] & ~(we_hi_v[0] & same_addr),
                          we_lo_v[1] & ~(we_lo_v[0] & same_addr)};
    end

    dpram_bank #(.W(2), .LO_W(1), .AW(ADDR_W)) u_own (
      .clk(clk_v[p]), .we_lo(own_we[p][0]), .we_hi(own_we[p][1]),
      .waddr(addr_v[p]), .wdata(own_wd[p]),
      .ra0(addr_v[0]), .ra1(addr_v[1]),
      .rd0(own_rd[p][0]), .rd1(own_rd[p][1]));
  end
endmodule

// File: tb/dpram_top_tb.sv
module dpram_top_tb_top;
  localparam int DW    = 18;
  localparam int AW    = 6;
  localparam int DEPTH = 2 ** AW;
  localparam int LW    = DW / 2;
  localparam logic [DW-1:0] LO_M = (DW'(1) << LW) - DW'(1);
  localparam logic [DW-1:0] HI_M = ~LO_M;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] addr  [2];
  logic [DW-1:0] wdata [2];
  logic rw_n [2], ce0_n [2], ce1 [2], ub_n [2], lb_n [2], oe_n [2], pipe [2];
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;

  dpram_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .a_clk(clk), .b_clk(clk), .rst_n(rst_n),
    .a_addr(addr[0]), .a_wdata(wdata[0]), .a_rw_n(rw_n[0]), .a_ce0_n(ce0_n[0]),
    .a_ce1(ce1[0]), .a_ub_n(ub_n[0]), .a_lb_n(lb_n[0]), .a_oe_n(oe_n[0]),
    .a_pipe(pipe[0]), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_addr(addr[1]), .b_wdata(wdata[1]), .b_rw_n(rw_n[1]), .b_ce0_n(ce0_n[1]),
    .b_ce1(ce1[1]), .b_ub_n(ub_n[1]), .b_lb_n(lb_n[1]), .b_oe_n(oe_n[1]),
    .b_pipe(pipe[1]), .b_rdata(b_rdata), .b_rvalid(b_rvalid));

  // Behavioural reference model
  logic [DW-1:0] mem_m [DEPTH];
  logic          s1v [2], s2v [2];
  logic [DW-1:0] s1d [2], s2d [2];

  int checks = 0;
  int fails  = 0;
  string tag = "reset";

  task automatic check(input string what, input int p, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s port%0d %s actual=%h expected=%h", tag, p, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic          nv [2];
    logic [DW-1:0] nd [2];
    for (int p = 0; p < 2; p++) begin
      logic sel, rd;
      logic [DW-1:0] m;
      sel = !ce0_n[p] && ce1[p];
      rd  = sel && rw_n[p];
      m   = (ub_n[p] ? '0 : HI_M) | (lb_n[p] ? '0 : LO_M);
      nv[p] = rd;
      nd[p] = rd ? (mem_m[addr[p]] & m) : '0;
    end
    for (int p = 0; p < 2; p++) begin
      s2v[p] = s1v[p]; s2d[p] = s1d[p];
      s1v[p] = nv[p];  s1d[p] = nd[p];
    end
    // port B first, then port A, so A wins a shared lane (R8)
    for (int p = 1; p >= 0; p--) begin
      if (!ce0_n[p] && ce1[p] && !rw_n[p]) begin
        if (!lb_n[p]) mem_m[addr[p]] = (mem_m[addr[p]] & HI_M) | (wdata[p] & LO_M);
        if (!ub_n[p]) mem_m[addr[p]] = (mem_m[addr[p]] & LO_M) | (wdata[p] & HI_M);
      end
    end
  endtask

  task automatic compare();
    for (int p = 0; p < 2; p++) begin
      logic          ev;
      logic [DW-1:0] ed;
      ev = (pipe[p] ? s2v[p] : s1v[p]) && !oe_n[p];
      ed = oe_n[p] ? '0 : (pipe[p] ? s2d[p] : s1d[p]);
      check("rvalid", p, DW'(p == 0 ? a_rvalid : b_rvalid), DW'(ev));
      check("rdata", p, p == 0 ? a_rdata : b_rdata, ed);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int p);
    addr[p] = '0; wdata[p] = '0; rw_n[p] = 1'b1; ce0_n[p] = 1'b1; ce1[p] = 1'b1;
    ub_n[p] = 1'b0; lb_n[p] = 1'b0; oe_n[p] = 1'b0;
  endtask

  task automatic wr(input int p, input int a, input logic [DW-1:0] d,
                    input logic u_n, input logic l_n);
    addr[p] = AW'(a); wdata[p] = d; rw_n[p] = 1'b0; ce0_n[p] = 1'b0; ce1[p] = 1'b1;
    ub_n[p] = u_n; lb_n[p] = l_n;
  endtask

  task automatic rd(input int p, input int a, input logic u_n, input logic l_n);
    addr[p] = AW'(a); rw_n[p] = 1'b1; ce0_n[p] = 1'b0; ce1[p] = 1'b1;
    ub_n[p] = u_n; lb_n[p] = l_n;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 32'h1357) ^ 32'h2a5a5);
  endfunction

  task automatic flush();
    idle(0); idle(1);
    cycle(); cycle();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    for (int p = 0; p < 2; p++) begin
      idle(p); pipe[p] = 1'b0;
      s1v[p] = 1'b0; s2v[p] = 1'b0; s1d[p] = '0; s2d[p] = '0;
    end
    repeat (3) @(negedge clk);
    tag = "R4 reset state";
    compare();
    rst_n = 1'b1;

    // R1 R10: fill every word from port A, a write never raises valid
    tag = "R1 R10 fill";
    for (int i = 0; i < DEPTH; i++) begin wr(0, i, pat(i), 1'b0, 1'b0); cycle(); end
    idle(0);
    // R1 R2: read everything back through port B in flow-through mode
    tag = "R1 R2 flow-through";
    for (int i = 0; i < DEPTH; i++) begin rd(1, i, 1'b0, 1'b0); cycle(); end
    flush();
    // R3: pipelined reads on port A
    tag = "R3 pipelined";
    pipe[0] = 1'b1;
    for (int i = 0; i < 16; i++) begin rd(0, DEPTH - 1 - i, 1'b0, 1'b0); cycle(); end
    flush();
    pipe[0] = 1'b0;

    // R5: lane-limited writes from both ports
    tag = "R5 lane writes";
    wr(0, 5, 18'h3ffff, 1'b1, 1'b0); wr(1, 6, 18'h3ffff, 1'b0, 1'b1); cycle();
    flush();
    rd(0, 5, 1'b0, 1'b0); rd(1, 6, 1'b0, 1'b0); cycle();
    flush();
    // R6: lane-limited reads
    tag = "R6 lane reads";
    rd(0, 7, 1'b0, 1'b1); rd(1, 7, 1'b1, 1'b0); cycle();
    rd(0, 8, 1'b1, 1'b1); cycle();
    flush();

    // R4: deselected writes do nothing and deselected reads give no data
    tag = "R4 deselect";
    wr(0, 9, 18'h00000, 1'b0, 1'b0); ce0_n[0] = 1'b1; cycle();
    wr(1, 10, 18'h00000, 1'b0, 1'b0); ce1[1] = 1'b0; cycle();
    idle(0); idle(1);
    rd(0, 9, 1'b0, 1'b0); ce1[0] = 1'b0; cycle();
    rd(0, 9, 1'b0, 1'b0); rd(1, 10, 1'b0, 1'b0); cycle();
    flush();

    // R7: output enable hides and restores held data
    tag = "R7 output enable";
    rd(0, 11, 1'b0, 1'b0); cycle();
    idle(0); oe_n[0] = 1'b1; cycle();
    @(negedge clk); oe_n[0] = 1'b0; #1 compare();
    flush();

    // R8: same-address writes on one edge
    tag = "R8 write collision";
    wr(0, 12, 18'h11111, 1'b0, 1'b0); wr(1, 12, 18'h22222, 1'b0, 1'b0); cycle();
    wr(0, 13, 18'h33333, 1'b1, 1'b0); wr(1, 13, 18'h0cccc, 1'b0, 1'b0); cycle();
    wr(0, 14, 18'h15555, 1'b0, 1'b1); wr(1, 14, 18'h2aaaa, 1'b1, 1'b0); cycle();
    idle(0); idle(1);
    rd(0, 12, 1'b0, 1'b0); rd(1, 13, 1'b0, 1'b0); cycle();
    rd(0, 14, 1'b0, 1'b0); rd(1, 12, 1'b0, 1'b0); cycle();
    flush();

    // R9: read meets write from the other port
    tag = "R9 read-write collision";
    rd(0, 15, 1'b0, 1'b0); wr(1, 15, 18'h1e1e1, 1'b0, 1'b0); cycle();
    wr(0, 16, 18'h0f0f0, 1'b0, 1'b0); rd(1, 16, 1'b0, 1'b0); cycle();
    idle(1);
    rd(0, 15, 1'b0, 1'b0); rd(1, 16, 1'b0, 1'b0); cycle();
    flush();

    // Mixed random traffic on a narrow address window
    tag = "random mix";
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < 2; p++) begin
        logic [31:0] r;
        r = $urandom;
        ce0_n[p] = (r[2:0] == 3'd0);
        ce1[p]   = (r[4:3] != 2'd0);
        rw_n[p]  = r[5];
        ub_n[p]  = (r[7:6] == 2'd0);
        lb_n[p]  = (r[9:8] == 2'd0);
        oe_n[p]  = (r[12:10] == 3'd0);
        addr[p]  = AW'(r[15:13]);
        if (r[20:16] == 5'd0) pipe[p] = ~pipe[p];
        wdata[p] = DW'($urandom);
      end
      cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule